// File: doc/BRIEF.md
# Frame Transmit Buffer Fetch Sequencer

This block assembles the byte stream of one outgoing synchronous data-link frame and feeds it, one byte at a time, to a downstream serializer over a ready/valid handshake. The CPU loads three configuration registers (the RAM address of the first information byte, the information-field length, and the control byte), then starts the frame by writing the go command. That command raises the buffer-full flag. While the flag is set, the configuration registers cannot be written.

Every frame begins with the control byte. After the control byte, the block reads information bytes from on-chip RAM at rising addresses. RAM reads take one cycle. The information field ends when the length count runs out, or earlier if the address would pass the top of the buffer (191); the address never wraps. When the last byte is accepted downstream, the block clears the flag, pulses a done strobe and records whether the top-of-buffer limit cut the frame short.

Top module: `txbuf_fetch_seq`

## Requirements
- R1: After reset, `buf_full`, `tx_valid`, `tx_last`, `mem_rd_en`, `frame_done` and `end_by_limit` are all 0.
- R2: A configuration write with `cfg_sel`=0 loads the start address, 1 loads the length and 2 loads the control byte. A write with `cfg_sel`=3 and `cfg_wdata[0]`=1 sets `buf_full` and starts a frame. A write with `cfg_sel`=3 and `cfg_wdata[0]`=0 has no effect.
- R3: While `buf_full` is 1, every configuration write is ignored. The frame in flight, and any later frame started without rewriting the registers, use the values that were present at go.
- R4: The first byte of every frame is the control byte. With a length of 0 it is the only byte.
- R5: The control byte is followed by information bytes read from RAM at start, start+1, and so on, in that order. The number of information bytes equals the length, unless R6 limits it.
- R6: No RAM read is issued at an address above 191. The information bytes stop after address 191 (a start above 191 gives none). `end_by_limit` reports 1 exactly when the length asked for more bytes than this allowed.
- R7: `tx_last` is 1 only together with the final byte of the frame, whether that byte is the control byte or an information byte.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is held unchanged.
- R9: In the cycle after the final byte is accepted, `frame_done` is 1 for exactly one cycle, `buf_full` is 0 and `end_by_limit` shows the result for that frame.
- R10: Each RAM read is issued in the same cycle that a byte is accepted downstream. Its data is presented as valid two cycles later (one cycle of RAM latency). The frame issues exactly one read per information byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 length, 2 control, 3 go |
| cfg_wdata | input | 8 | Configuration write data |
| buf_full | output | 1 | Frame pending or in flight; configuration is locked |
| mem_rd_en | output | 1 | RAM read request |
| mem_addr | output | 8 | RAM read address |
| mem_rdata | input | 8 | RAM read data, valid the cycle after the request |
| tx_data | output | 8 | Byte to the serializer |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_last | output | 1 | Current byte is the last of the frame |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| end_by_limit | output | 1 | Last frame was cut short by the top-of-buffer address |

## Verification
The hardest situation to reach is a configuration write that arrives while the frame is still in flight. Its only visible effect is the absence of any effect, so the bench cannot observe it directly. The bench therefore writes different values into all three registers right after go, on frames long enough to stay busy through those writes. It checks that the frame in flight is unchanged. It then starts a second frame without rewriting the registers and checks that this frame repeats the first.

Frames that meet the top of the buffer are placed directly against address 191: starts just below it, exactly at it and beyond it, and lengths that exactly fill it and lengths that overrun it. Random starts, random lengths and a randomly stalling `tx_ready` cover the hold behaviour and the fetch timing.

// File: rtl/txf_pkg.sv
// Package txf_pkg
// Shared encodings for the frame transmit fetch sequencer: the register
// select codes of the configuration port and the sequencer states.
package txf_pkg;

    // Configuration register select codes
    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_LEN   = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_GO    = 2'd3;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for the buffer-full flag
        ST_CTRL = 2'd1,   // presenting the control byte
        ST_WAIT = 2'd2,   // RAM read in flight
        ST_SEND = 2'd3    // presenting an information byte
    } seq_state_t;

endpackage

// File: rtl/txf_cfg_regs.sv
// Module txf_cfg_regs
// Holds the start address, the length and the control byte, plus the
// buffer-full flag. A go write sets the flag. Every write is refused while
// the flag is set. The sequencer clears the flag with frame_clear.
// Assumes: ADDR_W and LEN_W are no wider than DATA_W.
module txf_cfg_regs
    import txf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_clear,
    output logic [ADDR_W-1:0] base_addr,
    output logic [LEN_W-1:0]  info_len,
    output logic [DATA_W-1:0] ctrl_byte,
    output logic              busy
);

    logic write_ok;

    // Qualify CPU writes: accepted only while no frame is pending
    always_comb begin
        write_ok = wr_en && !busy;
    end

    // Register file and the buffer-full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            info_len  <= '0;
            ctrl_byte <= '0;
            busy      <= 1'b0;
        end else if (frame_clear) begin
            busy <= 1'b0;
        end else if (write_ok) begin
            case (wr_sel)
                SEL_START: base_addr <= wr_data[ADDR_W-1:0];
                SEL_LEN:   info_len  <= wr_data[LEN_W-1:0];
                SEL_CTRL:  ctrl_byte <= wr_data;
                default:   busy      <= wr_data[0];
            endcase
        end
    end

    // R3: configuration is frozen while a frame is pending
    a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_addr) && $stable(info_len) && $stable(ctrl_byte)));

    // R9: the flag only drops on a frame completion
    a_r9_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_clear) |=> busy);

endmodule

// File: rtl/txf_span_calc.sv
// Module txf_span_calc
// Works out how many information bytes a frame really carries, given the
// start address and the requested length, and the top-of-buffer address
// beyond which no byte may be read. Also flags when that cap truncated the
// request. Purely combinational.
module txf_span_calc #(
    parameter int ADDR_W   = 8,
    parameter int LEN_W    = 8,
    parameter int TOP_ADDR = 191
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  info_len,
    output logic [LEN_W:0]    info_cnt,
    output logic              limited
);

    localparam int SPAN_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;

    logic [SPAN_W-1:0] room;
    logic [SPAN_W-1:0] want;
    logic [SPAN_W-1:0] take;

    // Room left below the cap, then clip the request against it
    always_comb begin
        if (SPAN_W'(base_addr) <= SPAN_W'(TOP_ADDR))
            room = SPAN_W'(TOP_ADDR) - SPAN_W'(base_addr) + SPAN_W'(1);
        else
            room = '0;
        want     = SPAN_W'(info_len);
        limited  = (want > room);
        take     = limited ? room : want;
        info_cnt = take[LEN_W:0];
    end

endmodule

// File: rtl/txf_seq.sv
// Module txf_seq
// Frame byte sequencer. When the buffer-full flag is seen, it captures the
// frame plan and presents the control byte. On every accepted byte it
// issues the RAM read for the next information byte. The read data comes
// back one cycle later and is registered before it is presented. After the
// last byte it clears the flag, pulses done and latches the limit status.
// Assumes: a synchronous RAM with exactly one cycle of read latency.
module txf_seq
    import txf_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LEN_W    = 8,
    parameter int DATA_W   = 8,
    parameter int TOP_ADDR = 191
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] ctrl_byte,
    input  logic [LEN_W:0]    info_cnt,
    input  logic              limited,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic              frame_clear,
    output logic              frame_done,
    output logic              end_by_limit
);

    seq_state_t        state_q;
    logic [DATA_W-1:0] data_q;
    logic [LEN_W:0]    rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic              lim_q;
    logic              done_q;
    logic              lim_flag_q;
    logic              accept;
    logic              last_now;

    // Handshake, last-byte detection and read issue
    always_comb begin
        tx_valid    = (state_q == ST_CTRL) || (state_q == ST_SEND);
        accept      = tx_valid && tx_ready;
        last_now    = ((state_q == ST_CTRL) && (rem_q == '0)) ||
                      ((state_q == ST_SEND) && (rem_q == (LEN_W+1)'(1)));
        tx_last     = last_now;
        mem_rd_en   = accept && !last_now;
        frame_clear = accept && last_now;
        mem_addr    = addr_q;
        tx_data     = data_q;
    end

    // Status outputs, registered at frame completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            lim_flag_q <= 1'b0;
        end else begin
            done_q <= frame_clear;
            if (frame_clear)
                lim_flag_q <= lim_q;
        end
    end

    // Frame state machine: control byte, then fetch/present pairs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            rem_q   <= '0;
            addr_q  <= '0;
            lim_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (busy) begin
                        data_q  <= ctrl_byte;
                        rem_q   <= info_cnt;
                        addr_q  <= base_addr;
                        lim_q   <= limited;
                        state_q <= ST_CTRL;
                    end
                end
                ST_CTRL: begin
                    if (accept) begin
                        if (last_now) begin
                            state_q <= ST_IDLE;
                        end else begin
                            addr_q  <= addr_q + ADDR_W'(1);
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    data_q  <= mem_rdata;
                    state_q <= ST_SEND;
                end
                default: begin
                    if (accept) begin
                        rem_q <= rem_q - (LEN_W+1)'(1);
                        if (last_now) begin
                            state_q <= ST_IDLE;
                        end else begin
                            addr_q  <= addr_q + ADDR_W'(1);
                            state_q <= ST_WAIT;
                        end
                    end
                end
            endcase
        end
    end

    assign frame_done   = done_q;
    assign end_by_limit = lim_flag_q;

    // R8: a stalled byte is held
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10: reads only with a handshake, data presented two cycles later
    a_r10_fetch_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (tx_valid && tx_ready));
    a_r10_fetch_latency: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (!tx_valid ##1 tx_valid));

    // R6: the address never passes the top of the buffer
    a_r6_addr_cap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr <= ADDR_W'(TOP_ADDR)));

    // R9: done is a single pulse after the frame, with nothing presented
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!tx_valid && !busy && !$past(frame_done)));

    // R7: last only marks a presented byte
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

// File: rtl/txbuf_fetch_seq.sv
// Module txbuf_fetch_seq
// Top of the frame transmit buffer fetch sequencer. It ties together the
// configuration registers, the span calculation and the byte sequencer.
// Assumes: one RAM read port with a single cycle of latency, and a
// serializer that uses a ready/valid handshake.
module txbuf_fetch_seq #(
    parameter int ADDR_W   = 8,
    parameter int LEN_W    = 8,
    parameter int DATA_W   = 8,
    parameter int TOP_ADDR = 191
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              buf_full,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic              frame_done,
    output logic              end_by_limit
);

    logic [ADDR_W-1:0] base_addr;
    logic [LEN_W-1:0]  info_len;
    logic [DATA_W-1:0] ctrl_byte;
    logic [LEN_W:0]    info_cnt;
    logic              limited;
    logic              frame_clear;

    txf_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_sel      (cfg_sel),
        .wr_data     (cfg_wdata),
        .frame_clear (frame_clear),
        .base_addr   (base_addr),
        .info_len    (info_len),
        .ctrl_byte   (ctrl_byte),
        .busy        (buf_full)
    );

    txf_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TOP_ADDR(TOP_ADDR)) span_i (
        .base_addr (base_addr),
        .info_len  (info_len),
        .info_cnt  (info_cnt),
        .limited   (limited)
    );

    txf_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
              .TOP_ADDR(TOP_ADDR)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (buf_full),
        .base_addr    (base_addr),
        .ctrl_byte    (ctrl_byte),
        .info_cnt     (info_cnt),
        .limited      (limited),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_last      (tx_last),
        .frame_clear  (frame_clear),
        .frame_done   (frame_done),
        .end_by_limit (end_by_limit)
    );

endmodule

// File: tb/txbuf_fetch_seq_tb_top.sv
// Bench for txbuf_fetch_seq: directed boundary frames plus seeded random
// frames, a RAM model, and a randomly stalling serializer.
module txbuf_fetch_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       buf_full;
    logic       mem_rd_en;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata = 8'd0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       tx_last;
    logic       frame_done;
    logic       end_by_limit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int bad_rd = 0;
    int hold_err = 0;
    int rec_n = 0;
    int hs_cyc = 0;
    bit rand_ready = 1'b0;
    bit pend_hold = 1'b0;
    logic [7:0] held = 8'd0;
    logic [7:0] rec_data [0:16383];
    bit         rec_last [0:16383];

    always #10 clk = ~clk;

    txbuf_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .buf_full(buf_full), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
        .frame_done(frame_done), .end_by_limit(end_by_limit)
    );

    function automatic logic [7:0] memf(input int a);
        return 8'((a * 37 + 91) ^ (a >> 3));
    endfunction

    function automatic int room_of(input int s);
        return (s <= 191) ? (192 - s) : 0;
    endfunction

    function automatic int exp_info(input int s, input int l);
        return (l < room_of(s)) ? l : room_of(s);
    endfunction

    function automatic bit exp_lim(input int s, input int l);
        return l > room_of(s);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // RAM model with one cycle of latency and read accounting
    always @(posedge clk) begin
        cyc++;
        if (mem_rd_en) begin
            mem_rdata <= memf(int'(mem_addr));
            rd_cnt++;
            if (mem_addr > 8'd191) bad_rd++;
        end
    end

    // Serializer model: pick ready, then record the handshake of the next edge
    always @(negedge clk) begin
        tx_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
        if (pend_hold && (!tx_valid || tx_data != held)) hold_err++;
        pend_hold = tx_valid && !tx_ready;
        held = tx_data;
        if (tx_valid && tx_ready) begin
            rec_data[rec_n] = tx_data;
            rec_last[rec_n] = tx_last;
            rec_n++;
            hs_cyc = cyc;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
        cfg_wr_en = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic run_frame(input int s, input int l, input int c,
                             input bit load, input bit poke);
        int base;
        int rd0;
        int n;
        int ninfo;
        int bad_data;
        int bad_last;
        int done_cyc;
        bit seen;
        ninfo = exp_info(s, l);
        if (load) begin
            cfg_write(2'd0, 8'(s));
            cfg_write(2'd1, 8'(l));
            cfg_write(2'd2, 8'(c));
        end
        base = rec_n;
        rd0  = rd_cnt;
        cfg_write(2'd3, 8'd1);
        if (poke) begin
            // R3: writes while the frame is in flight must be ignored
            cfg_write(2'd2, ~8'(c));
            cfg_write(2'd1, 8'(l) ^ 8'h5a);
            cfg_write(2'd0, 8'(s + 3));
        end
        seen = 1'b0;
        done_cyc = 0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            if (frame_done) begin
                seen = 1'b1;
                done_cyc = cyc;
            end else begin
                @(negedge clk);
            end
        end
        check(seen, "R9 done seen", int'(seen), 1);
        check(done_cyc == hs_cyc + 1, "R9 done timing", done_cyc, hs_cyc + 1);
        check(!buf_full, "R9 flag cleared", int'(buf_full), 0);
        check(end_by_limit == exp_lim(s, l), "R6 end_by_limit",
              int'(end_by_limit), int'(exp_lim(s, l)));
        n = rec_n - base;
        check(n == ninfo + 1, "R5 byte count", n, ninfo + 1);
        check(rec_data[base] == 8'(c), "R4 control byte first",
              int'(rec_data[base]), c & 255);
        bad_data = 0;
        bad_last = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0 && rec_data[base + i] != memf(s + i - 1)) bad_data++;
            if (rec_last[base + i] != (i == n - 1)) bad_last++;
        end
        check(bad_data == 0, "R5 info bytes in address order", bad_data, 0);
        check(bad_last == 0, "R7 last marks final byte only", bad_last, 0);
        check(rd_cnt - rd0 == ninfo, "R10 one read per info byte", rd_cnt - rd0, ninfo);
        @(negedge clk);
        check(!frame_done, "R9 done single pulse", int'(frame_done), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        int l;
        int c;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!buf_full && !tx_valid && !tx_last, "R1 reset outputs",
              int'({buf_full, tx_valid, tx_last}), 0);
        check(!mem_rd_en && !frame_done && !end_by_limit, "R1 reset status",
              int'({mem_rd_en, frame_done, end_by_limit}), 0);

        // R2: go with bit 0 clear does nothing
        cfg_write(2'd3, 8'hFE);
        repeat (3) @(negedge clk);
        check(!buf_full && !tx_valid, "R2 go with bit0 clear ignored",
              int'({buf_full, tx_valid}), 0);

        // Directed corner cases
        run_frame(10, 0, 8'h3C, 1'b1, 1'b0);     // R4 zero length
        run_frame(20, 5, 8'hA5, 1'b1, 1'b0);     // R5 plain frame
        run_frame(188, 10, 8'h11, 1'b1, 1'b0);   // R6 truncated to 4
        run_frame(191, 1, 8'h22, 1'b1, 1'b0);    // R6 exact fit at top
        run_frame(191, 2, 8'h33, 1'b1, 1'b0);    // R6 one over
        run_frame(200, 3, 8'h44, 1'b1, 1'b0);    // R6 start above cap
        run_frame(200, 0, 8'h55, 1'b1, 1'b0);    // R4 zero length above cap
        run_frame(0, 192, 8'h66, 1'b1, 1'b0);    // R5 whole buffer, no limit
        run_frame(0, 255, 8'h77, 1'b1, 1'b0);    // R6 longest request

        // R3: writes during a frame ignored, next frame repeats the config
        rand_ready = 1'b1;
        run_frame(40, 6, 8'h5A, 1'b1, 1'b1);
        run_frame(40, 6, 8'h5A, 1'b0, 1'b0);
        run_frame(185, 20, 8'hC3, 1'b1, 1'b1);
        run_frame(185, 20, 8'hC3, 1'b0, 1'b0);

        // Random frames with a stalling serializer (R8)
        for (int k = 0; k < 24; k++) begin
            s = (k % 3 == 0) ? 160 + ($urandom % 64) : int'($urandom % 256);
            l = (k % 4 == 0) ? int'($urandom % 256) : int'($urandom % 24);
            c = int'($urandom % 256);
            run_frame(s, l, c, 1'b1, exp_info(s, l) >= 2);
        end

        check(hold_err == 0, "R8 stalled byte held", hold_err, 0);
        check(bad_rd == 0, "R6 no read above 191", bad_rd, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule